// File: doc/BRIEF.md
# Host Bridge Address Window Translator

This block sits between a processor request port and the ports that lead to the PCI side of a host bridge. Each cycle it may take one request: a 32-bit processor address, a byte count, a read/write flag and a valid strobe. It sorts the address into one of four windows: PCI I/O, PCI configuration, interrupt acknowledge and PCI memory. It then gives the downstream side a translated address, a one-hot window code and the request attributes it needs. Addresses that fall in no window are rejected, and so are requests whose size is illegal.

The I/O window has two foldings, and a mode pin picks between them. The contiguous folding maps the low part of the window onto a 64 KB space. The sparse folding takes address bits from the upper part of each 4 KB page and moves them down. Requests to the configuration window give a device number, found as the lowest set bit of a one-hot select field. The block routes and translates addresses only. It carries no data and runs no bus protocol.

All results are registered. They appear one cycle after the request and hold until the next request.

Top module: `hb_window_xlate`

## Requirements
- R1: While reset is asserted and after it is released, `rsp_valid`, `rsp_hit`, `rsp_addr`, `rsp_iack` and `rsp_err` are zero until the first request arrives.
- R2: `rsp_valid` is high in the cycle after each cycle in which `req_valid` is high and is low otherwise. When no request arrives, every other output keeps its value.
- R3: `rsp_hit` bit 0 marks I/O, bit 1 configuration, bit 2 interrupt acknowledge and bit 3 memory. At most one bit is set, and none is set when `rsp_err` is high.
- R4: In the I/O overlay (0x80000000 to 0x807FFFFF) with `io_map_sel` low, `rsp_addr` is the offset from 0x80000000 masked to its low 16 bits.
- R5: In the I/O overlay with `io_map_sel` high, `rsp_addr` bits 4:0 equal offset bits 4:0, bits 15:5 equal offset bits 22:12, and all higher bits are zero.
- R6: I/O addresses from 0x80C00000 to 0xBF7FFFFF give the unmodified offset from 0x80000000 in either mode.
- R7: Configuration addresses 0x80800000 to 0x80BFFFFF give `rsp_addr` = {device, offset[10:0]}. The device number is the index of the lowest set offset bit among bits 21:11, counted from 0, or 11 when none of those bits is set.
- R8: A one-byte read at 0xBFFFFFF0 sets hit bit 2 and `rsp_iack`, with `rsp_addr` zero. A one-byte write there sets hit bit 2 but leaves `rsp_iack` low. Any other size there sets `rsp_err`.
- R9: Addresses 0xC0000000 to 0xFEFFFFFF set hit bit 3, and `rsp_addr` is the offset from 0xC0000000.
- R10: An address outside every window sets `rsp_err` with a zero `rsp_hit` and a zero `rsp_addr`.
- R11: A `req_size` other than 1, 2 or 4 sets `rsp_err` in any window.
- R12: `rsp_size`, `rsp_write` and `rsp_lane` (request address bits 1:0) repeat the request's values.
- R13: `io_map_sel` is sampled with each request, so a mode change takes effect on the very next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Processor address |
| req_size | input | 3 | Access size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| io_map_sel | input | 1 | 0 = contiguous I/O folding, 1 = sparse folding |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 4 | One-hot window code |
| rsp_addr | output | 32 | Translated downstream address |
| rsp_size | output | 3 | Size passed through |
| rsp_write | output | 1 | Direction passed through |
| rsp_lane | output | 2 | Low address bits for byte-enable forming |
| rsp_iack | output | 1 | Interrupt-acknowledge read request |
| rsp_err | output | 1 | Decode error |

## Verification
The hardest case to reach is a change of folding mode between two back-to-back requests to the same overlay address. The output must follow the new mode at once, with no stale translation carried over. The bench drives the same address twice in consecutive cycles with `io_map_sel` flipped between them, and checks both results. The configuration decode is covered at its edge cases: the lowest and highest select bits, several select bits set at once, and no select bit set. Addresses on both sides of every window boundary are also driven.

// File: rtl/hbx_pkg.sv
package hbx_pkg;
  localparam int unsigned HIT_W = 4;
  localparam int unsigned HIT_IO = 0;
  localparam int unsigned HIT_CFG = 1;
  localparam int unsigned HIT_IACK = 2;
  localparam int unsigned HIT_MEM = 3;

  localparam logic [31:0] IO_BASE     = 32'h8000_0000;
  localparam logic [31:0] OVL_LAST    = 32'h807F_FFFF;
  localparam logic [31:0] CFG_BASE    = 32'h8080_0000;
  localparam logic [31:0] CFG_LAST    = 32'h80BF_FFFF;
  localparam logic [31:0] IO_HI_BASE  = 32'h80C0_0000;
  localparam logic [31:0] IO_LAST     = 32'hBF7F_FFFF;
  localparam logic [31:0] IACK_ADDR   = 32'hBFFF_FFF0;
  localparam logic [31:0] MEM_BASE    = 32'hC000_0000;
  localparam logic [31:0] MEM_LAST    = 32'hFEFF_FFFF;

  typedef struct packed {
    logic [HIT_W-1:0] hit;
    logic [31:0]      addr;
    logic             iack;
    logic             err;
  } dec_res_t;
endpackage

// File: rtl/hbx_cfg_dev.sv
module hbx_cfg_dev #(
  parameter int unsigned LOW_W  = 11,
  parameter int unsigned SCAN_W = 11,
  localparam int unsigned OFS_W = LOW_W + SCAN_W,
  localparam int unsigned DEV_W = $clog2(SCAN_W + 1),
  localparam int unsigned OUT_W = DEV_W + LOW_W
) (
  input  logic [OFS_W-1:0] ofs,
  output logic [OUT_W-1:0] cfg_addr
);
  logic [DEV_W-1:0] dev;
  logic [SCAN_W-1:0] sel;

  assign sel = ofs[OFS_W-1:LOW_W];

  // lowest set select bit wins; no bit gives SCAN_W
  always_comb begin
    dev = DEV_W'(SCAN_W);
    for (int i = SCAN_W - 1; i >= 0; i--) begin
      if (sel[i]) dev = DEV_W'(i);
    end
  end

  assign cfg_addr = {dev, ofs[LOW_W-1:0]};
endmodule

// File: rtl/hbx_io_fold.sv
module hbx_io_fold #(
  parameter int unsigned IO_W    = 16,
  parameter int unsigned KEEP_LO = 5,
  parameter int unsigned SRC_LO  = 12,
  localparam int unsigned MID_W  = IO_W - KEEP_LO,
  localparam int unsigned OFS_W  = SRC_LO + MID_W
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic             sparse,
  output logic [IO_W-1:0]  io_addr
);
  logic [IO_W-1:0] dense_a;
  logic [IO_W-1:0] sparse_a;

  generate
    if (OFS_W >= IO_W) begin : g_dense_wide
      assign dense_a = ofs[IO_W-1:0];
    end else begin : g_dense_narrow
      assign dense_a = IO_W'(ofs);
    end
  endgenerate

  assign sparse_a = {ofs[OFS_W-1:SRC_LO], ofs[KEEP_LO-1:0]};
  assign io_addr  = sparse ? sparse_a : dense_a;
endmodule

// File: rtl/hbx_decode.sv
module hbx_decode
  import hbx_pkg::*;
#(
  parameter int unsigned SIZE_W = 3
) (
  input  logic [31:0]       addr,
  input  logic [SIZE_W-1:0] size,
  input  logic              write,
  input  logic              sparse,
  output dec_res_t          res
);
  localparam int unsigned IO_W    = 16;
  localparam int unsigned OVL_W   = 23;
  localparam int unsigned CFG_W   = 22;
  localparam int unsigned CFGO_W  = 15;

  logic [31:0] io_ofs;
  logic [31:0] cfg_ofs;
  logic [31:0] mem_ofs;
  logic [IO_W-1:0]   ovl_addr;
  logic [CFGO_W-1:0] cfg_addr;
  logic in_ovl, in_cfg, in_io_hi, in_iack, in_mem, size_ok;

  assign io_ofs  = addr - IO_BASE;
  assign cfg_ofs = addr - CFG_BASE;
  assign mem_ofs = addr - MEM_BASE;

  assign in_ovl   = (addr >= IO_BASE)    && (addr <= OVL_LAST);
  assign in_cfg   = (addr >= CFG_BASE)   && (addr <= CFG_LAST);
  assign in_io_hi = (addr >= IO_HI_BASE) && (addr <= IO_LAST);
  assign in_iack  = (addr == IACK_ADDR);
  assign in_mem   = (addr >= MEM_BASE)   && (addr <= MEM_LAST);
  assign size_ok  = (size == SIZE_W'(1)) || (size == SIZE_W'(2)) || (size == SIZE_W'(4));

  hbx_io_fold #(.IO_W(IO_W), .KEEP_LO(5), .SRC_LO(12)) u_fold (
    .ofs     (io_ofs[OVL_W-1:0]),
    .sparse  (sparse),
    .io_addr (ovl_addr)
  );

  hbx_cfg_dev #(.LOW_W(11), .SCAN_W(11)) u_cfg (
    .ofs      (cfg_ofs[CFG_W-1:0]),
    .cfg_addr (cfg_addr)
  );

  always_comb begin
    res = '0;
    if (!size_ok) begin
      res.err = 1'b1;
    end else if (in_iack) begin
      if (size != SIZE_W'(1)) begin
        res.err = 1'b1;
      end else begin
        res.hit[HIT_IACK] = 1'b1;
        res.iack = !write;
      end
    end else if (in_cfg) begin
      res.hit[HIT_CFG] = 1'b1;
      res.addr = 32'(cfg_addr);
    end else if (in_ovl) begin
      res.hit[HIT_IO] = 1'b1;
      res.addr = 32'(ovl_addr);
    end else if (in_io_hi) begin
      res.hit[HIT_IO] = 1'b1;
      res.addr = io_ofs;
    end else if (in_mem) begin
      res.hit[HIT_MEM] = 1'b1;
      res.addr = mem_ofs;
    end else begin
      res.err = 1'b1;
    end
  end
endmodule

// File: rtl/hb_window_xlate.sv
module hb_window_xlate
  import hbx_pkg::*;
#(
  parameter int unsigned SIZE_W = 3,
  parameter int unsigned LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_write,
  input  logic              io_map_sel,
  output logic              rsp_valid,
  output logic [HIT_W-1:0]  rsp_hit,
  output logic [31:0]       rsp_addr,
  output logic [SIZE_W-1:0] rsp_size,
  output logic              rsp_write,
  output logic [LANE_W-1:0] rsp_lane,
  output logic              rsp_iack,
  output logic              rsp_err
);
  dec_res_t dec_now;
  dec_res_t res_q, res_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic write_q, write_d;
  logic valid_q, valid_d;

  hbx_decode #(.SIZE_W(SIZE_W)) u_dec (
    .addr   (req_addr),
    .size   (req_size),
    .write  (req_write),
    .sparse (io_map_sel),
    .res    (dec_now)
  );

  always_comb begin
    valid_d = req_valid;
    res_d   = res_q;
    size_d  = size_q;
    lane_d  = lane_q;
    write_d = write_q;
    if (req_valid) begin
      res_d   = dec_now;
      size_d  = req_size;
      lane_d  = req_addr[LANE_W-1:0];
      write_d = req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      size_q  <= '0;
      lane_q  <= '0;
      write_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      res_q   <= res_d;
      size_q  <= size_d;
      lane_q  <= lane_d;
      write_q <= write_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_hit   = res_q.hit;
  assign rsp_addr  = res_q.addr;
  assign rsp_iack  = res_q.iack;
  assign rsp_err   = res_q.err;
  assign rsp_size  = size_q;
  assign rsp_write = write_q;
  assign rsp_lane  = lane_q;
endmodule

// File: rtl/hbx_chk.sv
module hbx_chk #(
  parameter int unsigned SIZE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [SIZE_W-1:0] req_size,
  input logic              req_write,
  input logic              rsp_valid,
  input logic [3:0]        rsp_hit,
  input logic [31:0]       rsp_addr,
  input logic [SIZE_W-1:0] rsp_size,
  input logic              rsp_write,
  input logic              rsp_iack,
  input logic              rsp_err
);
  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R2
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_addr) && $stable(rsp_hit));
  // R3
  hit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(rsp_hit) == (rsp_err ? 0 : 1)));
  // R8
  iack_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_iack |-> rsp_hit[2] && !rsp_write && (rsp_size == SIZE_W'(1)));
  // R10
  err_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_addr == 32'd0) && (rsp_hit == 4'd0) && !rsp_iack);
  // R12
  attr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_size == $past(req_size)) && (rsp_write == $past(req_write)));
endmodule

bind hb_window_xlate hbx_chk #(.SIZE_W(SIZE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_size  (req_size),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_addr  (rsp_addr),
  .rsp_size  (rsp_size),
  .rsp_write (rsp_write),
  .rsp_iack  (rsp_iack),
  .rsp_err   (rsp_err)
);

// File: tb/hb_window_xlate_test.sv
module hb_window_xlate_test;
  typedef struct packed {
    logic [31:0] addr;
    logic [2:0]  size;
    logic        wr;
    logic        mode;
    logic [3:0]  hit;
    logic        err;
    logic [31:0] xa;
    logic        iack;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{32'h8000_1234, 3'd4, 1'b0, 1'b0, 4'b0001, 1'b0, 32'h0000_1234, 1'b0}, // R4
    '{32'h8012_F3C4, 3'd2, 1'b1, 1'b0, 4'b0001, 1'b0, 32'h0000_F3C4, 1'b0}, // R4
    '{32'h8012_F3C4, 3'd2, 1'b0, 1'b1, 4'b0001, 1'b0, 32'h0000_25E4, 1'b0}, // R5
    '{32'h807F_F01F, 3'd1, 1'b0, 1'b1, 4'b0001, 1'b0, 32'h0000_FFFF, 1'b0}, // R5
    '{32'h80C0_0010, 3'd4, 1'b0, 1'b1, 4'b0001, 1'b0, 32'h00C0_0010, 1'b0}, // R6
    '{32'hBF7F_FFFC, 3'd4, 1'b1, 1'b0, 4'b0001, 1'b0, 32'h3F7F_FFFC, 1'b0}, // R6
    '{32'h8080_0800, 3'd4, 1'b0, 1'b0, 4'b0010, 1'b0, 32'h0000_0000, 1'b0}, // R7
    '{32'h8080_1004, 3'd4, 1'b1, 1'b1, 4'b0010, 1'b0, 32'h0000_0804, 1'b0}, // R7
    '{32'h80A0_0108, 3'd2, 1'b0, 1'b0, 4'b0010, 1'b0, 32'h0000_5108, 1'b0}, // R7
    '{32'h8080_00FC, 3'd4, 1'b0, 1'b0, 4'b0010, 1'b0, 32'h0000_58FC, 1'b0}, // R7
    '{32'h80B0_1A40, 3'd1, 1'b0, 1'b1, 4'b0010, 1'b0, 32'h0000_0240, 1'b0}, // R7
    '{32'hBFFF_FFF0, 3'd1, 1'b0, 1'b0, 4'b0100, 1'b0, 32'h0000_0000, 1'b1}, // R8
    '{32'hBFFF_FFF0, 3'd1, 1'b1, 1'b0, 4'b0100, 1'b0, 32'h0000_0000, 1'b0}, // R8
    '{32'hBFFF_FFF0, 3'd2, 1'b0, 1'b0, 4'b0000, 1'b1, 32'h0000_0000, 1'b0}, // R8
    '{32'hC000_1000, 3'd4, 1'b0, 1'b0, 4'b1000, 1'b0, 32'h0000_1000, 1'b0}, // R9
    '{32'hFEFF_FFFF, 3'd1, 1'b1, 1'b0, 4'b1000, 1'b0, 32'h3EFF_FFFF, 1'b0}, // R9
    '{32'hFF00_0000, 3'd4, 1'b0, 1'b0, 4'b0000, 1'b1, 32'h0000_0000, 1'b0}, // R10
    '{32'h7FFF_FFFC, 3'd4, 1'b0, 1'b0, 4'b0000, 1'b1, 32'h0000_0000, 1'b0}, // R10
    '{32'hBF80_0000, 3'd1, 1'b0, 1'b0, 4'b0000, 1'b1, 32'h0000_0000, 1'b0}, // R10
    '{32'hBFFF_FFF1, 3'd1, 1'b0, 1'b0, 4'b0000, 1'b1, 32'h0000_0000, 1'b0}, // R10
    '{32'h8000_0000, 3'd3, 1'b0, 1'b0, 4'b0000, 1'b1, 32'h0000_0000, 1'b0}, // R11
    '{32'hC000_0002, 3'd0, 1'b1, 1'b0, 4'b0000, 1'b1, 32'h0000_0000, 1'b0}, // R11
    '{32'h8000_0003, 3'd1, 1'b1, 1'b0, 4'b0001, 1'b0, 32'h0000_0003, 1'b0}  // R12
  };

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, io_map_sel;
  logic [31:0] req_addr;
  logic [2:0]  req_size;
  logic rsp_valid, rsp_write, rsp_iack, rsp_err;
  logic [3:0]  rsp_hit;
  logic [31:0] rsp_addr;
  logic [2:0]  rsp_size;
  logic [1:0]  rsp_lane;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hb_window_xlate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .io_map_sel(io_map_sel),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
    .rsp_size(rsp_size), .rsp_write(rsp_write), .rsp_lane(rsp_lane),
    .rsp_iack(rsp_iack), .rsp_err(rsp_err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_vec(input vec_t v, input string tag);
    check(rsp_valid == 1'b1, {tag, " R2 valid"}, 32'(rsp_valid), 32'd1);
    check(rsp_hit == v.hit, {tag, " R3 hit"}, 32'(rsp_hit), 32'(v.hit));
    check(rsp_err == v.err, {tag, " err"}, 32'(rsp_err), 32'(v.err));
    check(rsp_addr == v.xa, {tag, " addr"}, rsp_addr, v.xa);
    check(rsp_iack == v.iack, {tag, " R8 iack"}, 32'(rsp_iack), 32'(v.iack));
    check(rsp_size == v.size && rsp_write == v.wr && rsp_lane == v.addr[1:0],
          {tag, " R12 attrs"}, {26'd0, rsp_size, rsp_write, rsp_lane},
          {26'd0, v.size, v.wr, v.addr[1:0]});
  endtask

  task automatic drive(input vec_t v);
    req_valid  = 1'b1;
    req_addr   = v.addr;
    req_size   = v.size;
    req_write  = v.wr;
    io_map_sel = v.mode;
  endtask

  initial begin
    #1500000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    vec_t va, vb;
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0; io_map_sel = 1'b0;
    repeat (3) @(negedge clk);
    // R1 state under reset
    check(rsp_valid == 0 && rsp_hit == 0 && rsp_addr == 0 && rsp_err == 0 && rsp_iack == 0,
          "R1 in reset", {rsp_valid, rsp_hit, rsp_err, rsp_iack, rsp_addr[24:0]}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(rsp_valid == 0 && rsp_hit == 0 && rsp_addr == 0 && rsp_err == 0 && rsp_iack == 0,
          "R1 after release", {rsp_valid, rsp_hit, rsp_err, rsp_iack, rsp_addr[24:0]}, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(negedge clk);
      req_valid = 1'b0;
      check_vec(VEC[i], $sformatf("vec%0d", i));
    end

    // R2 outputs hold without a request
    @(negedge clk);
    req_addr = 32'hC000_0040; req_size = 3'd4;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R2 idle valid", 32'(rsp_valid), 32'd0);
    check(rsp_addr == VEC[NV-1].xa && rsp_hit == VEC[NV-1].hit, "R2 hold",
          rsp_addr, VEC[NV-1].xa);

    // R13 back-to-back requests, mode flipped between them
    va = '{32'h8012_F3C4, 3'd2, 1'b0, 1'b0, 4'b0001, 1'b0, 32'h0000_F3C4, 1'b0};
    vb = '{32'h8012_F3C4, 3'd2, 1'b0, 1'b1, 4'b0001, 1'b0, 32'h0000_25E4, 1'b0};
    @(negedge clk);
    drive(va);
    @(negedge clk);
    check_vec(va, "R13 first");
    drive(vb);
    @(negedge clk);
    req_valid = 1'b0;
    check_vec(vb, "R13 second");
    vb.mode = 1'b0; vb.xa = 32'h0000_F3C4;
    drive(vb);
    @(negedge clk);
    req_valid = 1'b0;
    check_vec(vb, "R13 back to dense");

    // R1 reset mid-run clears results
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(rsp_valid == 0 && rsp_addr == 0 && rsp_hit == 0, "R1 re-reset",
          rsp_addr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule